// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit owns the program counter of a 32-bit core whose instructions are all four bytes long. Each cycle, decode hands it a control class, two register operands, a 16-bit branch offset and a 26-bit jump field. From these the unit picks the next instruction address. The choices are the sequential successor, a PC-relative branch target, a jump target whose upper bits come from the PC, or a register value. The unit also requests a write of the return address into the link register when the class asks for one.

The PC is a register inside the unit. It loads the chosen address on a rising clock edge when `advance` is high. The taken flag, the link-write request and the misaligned-target flag are registered on the same edge, so each one describes the step that just completed. While `advance` is low the PC holds and all three flags read zero. A synchronous reset loads the parameter `RESET_VEC` into the PC.

Class codes on `ctl`: 0 sequential; 1 branch if equal; 2 branch if not equal; 3 branch if less-or-equal zero; 4 branch if greater than zero; 5 branch if less than zero; 6 branch if greater-or-equal zero; 7 less-than-zero branch with link; 8 greater-or-equal-zero branch with link; 9 jump; 10 jump with link; 11 register jump; 12 register jump with link; 13 to 15 unused.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes `RESET_VEC` and `taken_q`, `link_we_q` and `misalign_q` become 0.
- R2: With `advance` high and class 0, the PC becomes PC+4 and `taken_q` is 0.
- R3: Classes 1 and 2 compare `opnd_a` with `opnd_b` for equality and inequality. When the condition holds, the PC becomes PC+4 plus the sign-extended offset times 4 and `taken_q` is 1. Otherwise the PC becomes PC+4 and `taken_q` is 0.
- R4: Classes 3 to 6 test `opnd_a` as a two's-complement number against zero (<=0, >0, <0, >=0). The taken target is the same as in R3.
- R5: Classes 7 (<0) and 8 (>=0) branch as in R4. Whether or not the branch is taken, they assert `link_we_q` with `link_addr_q` = 31 and `link_data_q` = old PC+4.
- R6: Class 9 sets the PC to {bits 31:28 of PC+4, `jmp_field`, 2'b00} with `taken_q` 1.
- R7: Class 10 jumps as in R6 and also requests a link write of old PC+4 into register 31.
- R8: Classes 11 and 12 load the PC from `opnd_a` when its bits 1:0 are 00, with `taken_q` 1. Class 12 also requests the link write of old PC+4 into register 31.
- R9: For class 11 or 12 with `opnd_a[1:0]` not 00, the PC keeps its value, `misalign_q` is 1, and `taken_q` and `link_we_q` are 0.
- R10: While `advance` is low, the PC holds and `taken_q`, `link_we_q` and `misalign_q` are 0 after the edge.
- R11: Class codes 13 to 15 behave as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Step the PC on this edge |
| ctl | input | 4 | Control class code |
| opnd_a | input | 32 | First register operand (also register-jump target) |
| opnd_b | input | 32 | Second register operand |
| br_offset | input | 16 | Signed word offset for branches |
| jmp_field | input | 26 | Word target field for jumps |
| pc_q | output | 32 | Current program counter |
| taken_q | output | 1 | Last step redirected the PC |
| link_we_q | output | 1 | Last step requests a link register write |
| link_addr_q | output | 5 | Destination register of the link write |
| link_data_q | output | 32 | Return address for the link write |
| misalign_q | output | 1 | Last step was a register jump to an unaligned address |

## Verification
Every result is due on the first rising edge after the inputs are applied with `advance` high. This holds for the new PC and for all flags. There is no deeper pipeline, so the bench sets the inputs on a falling edge. It compares all outputs on the next falling edge, half a period after the edge that updated them. The reference model advances its PC only when that comparison is made. This keeps model and design in step even after held or faulting steps.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [3:0] {
    CL_SEQ      = 4'd0,
    CL_BR_EQ    = 4'd1,
    CL_BR_NE    = 4'd2,
    CL_BR_LEZ   = 4'd3,
    CL_BR_GTZ   = 4'd4,
    CL_BR_LTZ   = 4'd5,
    CL_BR_GEZ   = 4'd6,
    CL_BR_LTZ_L = 4'd7,
    CL_BR_GEZ_L = 4'd8,
    CL_JMP      = 4'd9,
    CL_JMP_L    = 4'd10,
    CL_JREG     = 4'd11,
    CL_JREG_L   = 4'd12,
    CL_RSV13    = 4'd13,
    CL_RSV14    = 4'd14,
    CL_RSV15    = 4'd15
  } ctl_e;
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctl_e              cls,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              cond_ok
);
  logic neg, zero, same;

  assign neg  = op_a[DATA_W-1];
  assign zero = (op_a == '0);
  assign same = (op_a == op_b);

  always_comb begin
    unique case (cls)
      CL_BR_EQ:                 cond_ok = same;
      CL_BR_NE:                 cond_ok = !same;
      CL_BR_LEZ:                cond_ok = neg || zero;
      CL_BR_GTZ:                cond_ok = !neg && !zero;
      CL_BR_LTZ, CL_BR_LTZ_L:   cond_ok = neg;
      CL_BR_GEZ, CL_BR_GEZ_L:   cond_ok = !neg;
      default:                  cond_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int JT_W   = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [JT_W-1:0]   field,
  output logic [ADDR_W-1:0] pc_plus4,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] jmp_target
);
  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam int HI_W  = ADDR_W - JT_W - 2;

  logic [ADDR_W-1:0] disp;

  assign pc_plus4 = pc + ADDR_W'(4);

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    end else begin : g_noext
      assign disp = {offset[ADDR_W-3:0], 2'b00};
    end
  endgenerate

  assign br_target = pc_plus4 + disp;

  generate
    if (HI_W > 0) begin : g_hi
      assign jmp_target = {pc_plus4[ADDR_W-1 -: HI_W], field, 2'b00};
    end else begin : g_nohi
      assign jmp_target = {field[ADDR_W-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              OFF_W     = 16,
  parameter int              JT_W      = 26,
  parameter int              REG_W     = 5,
  parameter int              LINK_REG  = 31,
  parameter logic [31:0]     RESET_VEC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [3:0]        ctl,
  input  logic [ADDR_W-1:0] opnd_a,
  input  logic [ADDR_W-1:0] opnd_b,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [JT_W-1:0]   jmp_field,
  output logic [ADDR_W-1:0] pc_q,
  output logic              taken_q,
  output logic              link_we_q,
  output logic [REG_W-1:0]  link_addr_q,
  output logic [ADDR_W-1:0] link_data_q,
  output logic              misalign_q
);
  localparam int HI_W = ADDR_W - JT_W - 2;

  ctl_e              cls;
  logic              cond_ok;
  logic [ADDR_W-1:0] pcp4, br_tgt, jmp_tgt;
  logic [ADDR_W-1:0] nxt_pc;
  logic              nxt_taken, nxt_link, nxt_mis;

  assign cls = ctl_e'(ctl);

  nextpc_cond #(.DATA_W(ADDR_W)) u_cond (
    .cls     (cls),
    .op_a    (opnd_a),
    .op_b    (opnd_b),
    .cond_ok (cond_ok)
  );

  nextpc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
    .pc         (pc_q),
    .offset     (br_offset),
    .field      (jmp_field),
    .pc_plus4   (pcp4),
    .br_target  (br_tgt),
    .jmp_target (jmp_tgt)
  );

  always_comb begin
    nxt_pc    = pcp4;
    nxt_taken = 1'b0;
    nxt_link  = 1'b0;
    nxt_mis   = 1'b0;
    unique case (cls)
      CL_BR_EQ, CL_BR_NE, CL_BR_LEZ, CL_BR_GTZ,
      CL_BR_LTZ, CL_BR_GEZ, CL_BR_LTZ_L, CL_BR_GEZ_L: begin
        if (cond_ok) begin
          nxt_pc    = br_tgt;
          nxt_taken = 1'b1;
        end
        nxt_link = (cls == CL_BR_LTZ_L) || (cls == CL_BR_GEZ_L);
      end
      CL_JMP, CL_JMP_L: begin
        nxt_pc    = jmp_tgt;
        nxt_taken = 1'b1;
        nxt_link  = (cls == CL_JMP_L);
      end
      CL_JREG, CL_JREG_L: begin
        if (opnd_a[1:0] != 2'b00) begin
          nxt_pc  = pc_q;
          nxt_mis = 1'b1;
        end else begin
          nxt_pc    = opnd_a;
          nxt_taken = 1'b1;
          nxt_link  = (cls == CL_JREG_L);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RESET_VEC[ADDR_W-1:0];
      taken_q     <= 1'b0;
      link_we_q   <= 1'b0;
      link_addr_q <= '0;
      link_data_q <= '0;
      misalign_q  <= 1'b0;
    end else if (advance) begin
      pc_q        <= nxt_pc;
      taken_q     <= nxt_taken;
      link_we_q   <= nxt_link;
      link_addr_q <= nxt_link ? REG_W'(LINK_REG) : '0;
      link_data_q <= pcp4;
      misalign_q  <= nxt_mis;
    end else begin
      taken_q     <= 1'b0;
      link_we_q   <= 1'b0;
      link_addr_q <= '0;
      misalign_q  <= 1'b0;
    end
  end

  // Sequential step adds exactly one instruction word.
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && ctl == 4'd0) |=> (pc_q == $past(pc_q) + ADDR_W'(4)));

  // Jump keeps the region bits of PC+4 and lands word aligned.
  assert_jump_region_R6: assert property (@(posedge clk) disable iff (rst)
    (advance && (ctl == 4'd9 || ctl == 4'd10)) |=>
      (pc_q[1:0] == 2'b00 && pc_q[ADDR_W-1 -: HI_W] == $past(pcp4[ADDR_W-1 -: HI_W])));

  // Return address is the word after the instruction that linked.
  assert_link_data_R7: assert property (@(posedge clk) disable iff (rst)
    link_we_q |-> (link_data_q == $past(pc_q) + ADDR_W'(4)));

  // A faulting register jump leaves the PC where it was.
  assert_misalign_hold_R9: assert property (@(posedge clk) disable iff (rst)
    misalign_q |-> ($stable(pc_q) && !taken_q && !link_we_q));

  // No step: PC holds and no flag is raised.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(pc_q) && !taken_q && !link_we_q && !misalign_q));
endmodule

// File: tb/test_nextpc_unit.sv
`timescale 1ns/100ps
module test_nextpc_unit;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [3:0]  ctl = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] br_offset = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] pc_q, link_data_q;
  logic        taken_q, link_we_q, misalign_q;
  logic [4:0]  link_addr_q;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc;

  always #2.5 clk = ~clk;

  nextpc_unit #(.RESET_VEC(RV)) i_nextpc_unit (
    .clk(clk), .rst(rst), .advance(advance), .ctl(ctl),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_offset(br_offset), .jmp_field(jmp_field),
    .pc_q(pc_q), .taken_q(taken_q), .link_we_q(link_we_q), .link_addr_q(link_addr_q),
    .link_data_q(link_data_q), .misalign_q(misalign_q)
  );

  function automatic string tag_of(input logic [3:0] c, input logic [31:0] a, input logic adv);
    if (!adv) return "R10";
    case (c)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7, 4'd8: return "R5";
      4'd9: return "R6";
      4'd10: return "R7";
      4'd11, 4'd12: return (a[1:0] != 2'b00) ? "R9" : "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic step(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] off, input logic [25:0] jt, input logic adv,
                      input string tag);
    logic [31:0] e_pc, p4, e_ld;
    logic        e_tk, e_lw, e_mis, jump_ok;
    int signed   sa;
    ctl = c; opnd_a = a; opnd_b = b; br_offset = off; jmp_field = jt; advance = adv;
    sa = $signed(a);
    p4 = m_pc + 32'd4;
    e_pc = m_pc; e_tk = 0; e_lw = 0; e_mis = 0; e_ld = p4;
    if (adv) begin
      e_pc = p4;
      jump_ok = 0;
      case (c)
        4'd1: jump_ok = (a == b);
        4'd2: jump_ok = (a != b);
        4'd3: jump_ok = (sa <= 0);
        4'd4: jump_ok = (sa > 0);
        4'd5: jump_ok = (sa < 0);
        4'd6: jump_ok = (sa >= 0);
        4'd7: begin jump_ok = (sa < 0);  e_lw = 1; end
        4'd8: begin jump_ok = (sa >= 0); e_lw = 1; end
        default: ;
      endcase
      if (jump_ok) begin
        e_pc = p4 + 32'($signed(off) * 4);
        e_tk = 1;
      end
      if (c == 4'd9 || c == 4'd10) begin
        e_pc = (p4 & 32'hF000_0000) | (32'(jt) * 4);
        e_tk = 1;
        e_lw = (c == 4'd10);
      end
      if (c == 4'd11 || c == 4'd12) begin
        if (a[1:0] != 2'b00) begin
          e_pc = m_pc; e_mis = 1;
        end else begin
          e_pc = a; e_tk = 1; e_lw = (c == 4'd12);
        end
      end
    end
    @(negedge clk);
    checks++;
    if (pc_q !== e_pc || taken_q !== e_tk || link_we_q !== e_lw || misalign_q !== e_mis ||
        (e_lw && (link_addr_q !== 5'd31 || link_data_q !== e_ld))) begin
      errors++;
      $display("FAIL %s ctl=%0d: pc=%h tk=%b lw=%b la=%0d ld=%h mis=%b expected pc=%h tk=%b lw=%b la=%0d ld=%h mis=%b",
               tag, c, pc_q, taken_q, link_we_q, link_addr_q, link_data_q, misalign_q,
               e_pc, e_tk, e_lw, e_lw ? 31 : 0, e_ld, e_mis);
    end
    m_pc = e_pc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pc_q !== RV || taken_q !== 1'b0 || link_we_q !== 1'b0 || misalign_q !== 1'b0) begin
      errors++;
      $display("FAIL R1: pc=%h tk=%b lw=%b mis=%b expected pc=%h flags 0",
               pc_q, taken_q, link_we_q, misalign_q, RV);
    end
    rst = 1'b0;
    m_pc = RV;
    step(4'd0, 0, 0, 0, 0, 1, "R2");
    step(4'd0, 0, 0, 0, 0, 1, "R2");
    step(4'd9, 0, 0, 0, 26'h123, 0, "R10");
    step(4'd1, 32'd7, 32'd7, 16'd3, 0, 1, "R3");
    step(4'd1, 32'd7, 32'd8, 16'd3, 0, 1, "R3");
    step(4'd2, 32'd1, 32'd2, 16'hFFFE, 0, 1, "R3");
    step(4'd3, 32'd0, 0, 16'd5, 0, 1, "R4");
    step(4'd4, 32'd0, 0, 16'd5, 0, 1, "R4");
    step(4'd5, 32'h8000_0000, 0, 16'hFFF0, 0, 1, "R4");
    step(4'd6, 32'hFFFF_FFFF, 0, 16'd5, 0, 1, "R4");
    step(4'd7, 32'd5, 0, 16'd9, 0, 1, "R5");
    step(4'd8, 32'd0, 0, 16'd9, 0, 1, "R5");
    step(4'd9, 0, 0, 0, 26'h3FF_FFFF, 1, "R6");
    step(4'd11, 32'h1FFF_FFFC, 0, 0, 0, 1, "R8");
    step(4'd9, 0, 0, 0, 26'h000_0010, 1, "R6");
    step(4'd10, 0, 0, 0, 26'h001_0000, 1, "R7");
    step(4'd12, 32'h0000_2000, 0, 0, 0, 1, "R8");
    step(4'd11, 32'h0000_3002, 0, 0, 0, 1, "R9");
    step(4'd12, 32'h0000_3001, 0, 0, 0, 1, "R9");
    step(4'd13, 32'd1, 32'd1, 16'd4, 26'h55, 1, "R11");
    step(4'd15, 32'd0, 32'd0, 16'd4, 26'h55, 1, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  c;
      logic [31:0] a, b;
      logic        adv;
      c   = 4'($urandom_range(0, 15));
      a   = $urandom;
      b   = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 1) == 0) a[1:0] = 2'b00;
      if ($urandom_range(0, 3) == 0) a = 32'd0;
      adv = ($urandom_range(0, 7) != 0);
      step(c, a, b, 16'($urandom), 26'($urandom), adv, tag_of(c, a, adv));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule